// File: doc/BRIEF.md
# SDRAM Burst Column and Data-Mask Sequencer

This block sits between a memory controller's command logic and the SDRAM pins. When a read or write command starts, it produces one column address per clock for each beat of the burst. The burst length, the wrap order (sequential or interleaved) and the read latency come from mode fields. For reads it also marks the clock in which each beat's data appears on the data bus and says whether the bus is driven in that clock. For writes it marks which beats really carry data, after the data mask is applied.

A burst ends on its own after the programmed number of beats. An explicit stop ends it sooner. A new command that arrives mid-burst also ends it, and the new burst's first beat follows in the next clock. In full-page mode the column walks through the whole column space and wraps around until it is stopped. The data mask acts at once on writes and two clocks later on reads.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beat_vld`, `data_vld` and `dq_oe` are low until a command is given.
- R2: If `go` is high in cycle c, the first beat appears in cycle c+1, with `beat_col` equal to the `start_col` sampled in cycle c. The following beats come in consecutive cycles.
- R3: `bl_code` selects the number of beats: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8, and 3'b111 gives full page. Any other code behaves as 1 beat.
- R4: With `ilv` low and a burst length L of 2, 4 or 8, beat i has column (start with its low log2(L) bits cleared) + ((start mod L + i) mod L).
- R5: With `ilv` high and a burst length L of 2, 4 or 8, beat i has column (start with its low log2(L) bits cleared) + ((start mod L) XOR i).
- R6: In full-page mode, beat i has column (start + i) mod 2^COL_W. The burst does not end by itself, and `ilv` is ignored.
- R7: If `stop` is high in cycle c and `go` is low, no beat appears from cycle c+1 on. The beat shown in cycle c was still issued.
- R8: If `go` is high while a burst is running, the old burst issues no further beats. The new burst's first beat appears in the next cycle and uses the new start column and mode.
- R9: For a read beat in cycle b, `data_vld` is high in cycle b+CL, where CL is 2 when `cl3` is 0 and 3 when `cl3` is 1.
- R10: In a read data cycle d, `dq_oe` equals `data_vld`, except that it is low when `dqm` was high in cycle d-2.
- R11: In a write beat cycle, `data_vld` is high exactly when `dqm` is low in that same cycle. `dq_oe` stays low for write bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse for a read or write burst |
| wr_en | input | 1 | 1 = write burst, 0 = read burst (sampled with `go`) |
| start_col | input | COL_W | First column of the burst (sampled with `go`) |
| bl_code | input | 3 | Burst length code (sampled with `go`) |
| ilv | input | 1 | 1 = interleaved wrap order (sampled with `go`) |
| cl3 | input | 1 | Read latency select: 0 = 2 clocks, 1 = 3 clocks |
| dqm | input | 1 | Data mask |
| stop | input | 1 | Ends the running burst |
| beat_col | output | COL_W | Column address of the current beat |
| beat_vld | output | 1 | A beat is issued this cycle |
| data_vld | output | 1 | Data slot this cycle (read return, or unmasked write beat) |
| dq_oe | output | 1 | Read data bus driven this cycle |

## Verification
The hardest case to reach from the ports is the one where the mask pipeline, the read latency pipeline and burst termination all act on the same data cycles. A mask pulse must land two cycles before a read data slot that belongs to a beat issued just before a stop. To get there, the stimulus drives a per-cycle mask pattern together with a stop placed at a chosen beat. The expected data and output-enable cycles are then computed from the beat cycles plus the latency. Overlapping commands are tested separately by issuing a second `go` while an eight-beat burst is still running.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [2:0] {
    BLC_1    = 3'b000,
    BLC_2    = 3'b001,
    BLC_4    = 3'b010,
    BLC_8    = 3'b011,
    BLC_PAGE = 3'b111
  } bl_code_e;

  localparam int RD_PIPE_DEPTH = 3;
endpackage

// File: rtl/bseq_mode_dec.sv
module bseq_mode_dec
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic [2:0]       bl_code,
  input  logic             ilv,
  output logic [COL_W-1:0] wrap_mask,
  output logic             full_page,
  output logic             ilv_eff
);
  always_comb begin
    wrap_mask = '0;
    full_page = 1'b0;
    case (bl_code)
      BLC_2:    wrap_mask = COL_W'(1);
      BLC_4:    wrap_mask = COL_W'(3);
      BLC_8:    wrap_mask = COL_W'(7);
      BLC_PAGE: begin
        wrap_mask = '1;
        full_page = 1'b1;
      end
      default:  wrap_mask = '0;
    endcase
    ilv_eff = ilv & ~full_page;
  end
endmodule

// File: rtl/bseq_addr_gen.sv
module bseq_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             wr_en,
  input  logic             stop,
  input  logic [COL_W-1:0] start_col,
  input  logic [COL_W-1:0] mask_in,
  input  logic             full_in,
  input  logic             ilv_in,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_vld,
  output logic             beat_wr
);
  logic             act_q, act_d;
  logic             wr_q, wr_d;
  logic             full_q, full_d;
  logic             ilv_q, ilv_d;
  logic [COL_W-1:0] idx_q, idx_d;
  logic [COL_W-1:0] base_q, base_d;
  logic [COL_W-1:0] mask_q, mask_d;
  logic [COL_W-1:0] off;
  logic             last_beat;

  assign last_beat = ~full_q & (idx_q == mask_q);

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    full_d = full_q;
    ilv_d  = ilv_q;
    idx_d  = idx_q;
    base_d = base_q;
    mask_d = mask_q;
    if (go) begin
      act_d  = 1'b1;
      wr_d   = wr_en;
      full_d = full_in;
      ilv_d  = ilv_in;
      idx_d  = '0;
      base_d = start_col;
      mask_d = mask_in;
    end else if (act_q) begin
      if (stop || last_beat) begin
        act_d = 1'b0;
      end else begin
        idx_d = idx_q + COL_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      full_q <= full_d;
      ilv_q  <= ilv_d;
      idx_q  <= idx_d;
      base_q <= base_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    if (ilv_q) off = base_q ^ idx_q;
    else       off = base_q + idx_q;
    beat_col = (base_q & ~mask_q) | (off & mask_q);
  end

  assign beat_vld = act_q;
  assign beat_wr  = wr_q;

  // R4: sequential beats step by one inside the wrap block
  assert_seq_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q) && !$past(go) && !ilv_q && !full_q)
      |-> ((beat_col & mask_q) == (($past(beat_col) + COL_W'(1)) & mask_q)));

  // R6: full page continues unless stopped or restarted
  assert_page_runs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && full_q && !stop && !go) |=> act_q);
endmodule

// File: rtl/bseq_data_align.sv
module bseq_data_align
  import burst_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic beat_vld,
  input  logic beat_wr,
  input  logic cl3,
  input  logic dqm,
  output logic data_vld,
  output logic dq_oe
);
  logic [RD_PIPE_DEPTH-1:0] rd_sr_q, rd_sr_d;
  logic [1:0]               dqm_sr_q, dqm_sr_d;
  logic                     rd_slot;
  logic                     wr_slot;

  always_comb begin
    rd_sr_d  = {rd_sr_q[RD_PIPE_DEPTH-2:0], beat_vld & ~beat_wr};
    dqm_sr_d = {dqm_sr_q[0], dqm};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_sr_q  <= '0;
      dqm_sr_q <= '0;
    end else begin
      rd_sr_q  <= rd_sr_d;
      dqm_sr_q <= dqm_sr_d;
    end
  end

  assign rd_slot  = cl3 ? rd_sr_q[2] : rd_sr_q[1];
  assign wr_slot  = beat_vld & beat_wr & ~dqm;
  assign data_vld = rd_slot | wr_slot;
  assign dq_oe    = rd_slot & ~dqm_sr_q[1];

  // R10: a mask two cycles earlier always blanks the bus
  assert_rd_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !$past(dqm, 2));

  // R9: bus is only driven in a data slot
  assert_oe_in_slot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> data_vld);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             wr_en,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             ilv,
  input  logic             cl3,
  input  logic             dqm,
  input  logic             stop,
  output logic [COL_W-1:0] beat_col,
  output logic             beat_vld,
  output logic             data_vld,
  output logic             dq_oe
);
  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;
  logic             beat_wr;

  bseq_mode_dec #(.COL_W(COL_W)) mode_dec_i (
    .bl_code   (bl_code),
    .ilv       (ilv),
    .wrap_mask (dec_mask),
    .full_page (dec_full),
    .ilv_eff   (dec_ilv)
  );

  bseq_addr_gen #(.COL_W(COL_W)) addr_gen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .wr_en     (wr_en),
    .stop      (stop),
    .start_col (start_col),
    .mask_in   (dec_mask),
    .full_in   (dec_full),
    .ilv_in    (dec_ilv),
    .beat_col  (beat_col),
    .beat_vld  (beat_vld),
    .beat_wr   (beat_wr)
  );

  bseq_data_align data_align_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .beat_vld (beat_vld),
    .beat_wr  (beat_wr),
    .cl3      (cl3),
    .dqm      (dqm),
    .data_vld (data_vld),
    .dq_oe    (dq_oe)
  );

  // R2: first beat carries the start column
  assert_first_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (beat_vld && beat_col == $past(start_col)));

  // R7: stop without a new command ends the burst
  assert_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !go) |=> !beat_vld);

  // R3: single-beat burst issues exactly one beat
  assert_bl1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && bl_code == 3'b000) |=> ##1 (!beat_vld || $past(go)));
endmodule

// File: tb/burst_col_seq_tb_top.sv
module burst_col_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COL_W = 8;
  localparam int COLS  = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             go, wr_en, ilv, cl3, dqm, stop;
  logic [COL_W-1:0] start_col;
  logic [2:0]       bl_code;
  logic [COL_W-1:0] beat_col;
  logic             beat_vld, data_vld, dq_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .wr_en(wr_en), .start_col(start_col),
    .bl_code(bl_code), .ilv(ilv), .cl3(cl3), .dqm(dqm), .stop(stop),
    .beat_col(beat_col), .beat_vld(beat_vld), .data_vld(data_vld), .dq_oe(dq_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int blen_of(input logic [2:0] c);
    case (c)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic int ecol(input int s, input int i, input logic [2:0] c, input bit il);
    int bl = blen_of(c);
    int blk, o;
    if (bl == 0) return (s + i) % COLS;
    blk = (s / bl) * bl;
    o = s % bl;
    if (il) return blk + (o ^ i);
    return blk + ((o + i) % bl);
  endfunction

  // One command, observed for 20 cycles. stop_at: beat index during which stop is high (-1 none).
  task automatic burst(input string req, input bit w, input int s, input logic [2:0] c,
                       input bit il, input bit lat3, input int stop_at, input logic [20:0] pat);
    int bl = blen_of(c);
    int cnt, cl;
    cl = lat3 ? 3 : 2;
    cnt = (bl == 0) ? 1000 : bl;
    if (stop_at >= 0 && stop_at + 1 < cnt) cnt = stop_at + 1;
    @(negedge clk);
    go = 1'b1; wr_en = w; start_col = COL_W'(s); bl_code = c; ilv = il; cl3 = lat3;
    dqm = 1'b0; stop = 1'b0;
    for (int t = 1; t <= 20; t++) begin
      bit eb, ed, eo;
      @(negedge clk);
      go = 1'b0;
      stop = (stop_at == t - 1);
      dqm = pat[t];
      #1;
      eb = (t >= 1 && t <= cnt);
      if (w) begin
        ed = eb && !pat[t];
        eo = 1'b0;
      end else begin
        ed = (t - cl >= 1) && (t - cl <= cnt);
        eo = ed && !((t >= 2) && pat[t-2]);
      end
      chk(beat_vld == eb, req, "beat_vld", beat_vld, eb);
      if (eb) chk(int'(beat_col) == ecol(s, t - 1, c, il), req, "beat_col",
                  int'(beat_col), ecol(s, t - 1, c, il));
      chk(data_vld == ed, w ? "R11" : "R9", "data_vld", data_vld, ed);
      chk(dq_oe == eo, w ? "R11" : "R10", "dq_oe", dq_oe, eo);
    end
    stop = 1'b0; dqm = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; go = 0; wr_en = 0; start_col = '0; bl_code = '0;
    ilv = 0; cl3 = 0; dqm = 0; stop = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!beat_vld, "R1", "beat_vld", beat_vld, 0);
    chk(!data_vld, "R1", "data_vld", data_vld, 0);
    chk(!dq_oe,    "R1", "dq_oe", dq_oe, 0);
  endtask

  task automatic t_seq_lengths();
    burst("R2", 1, 8'h35, 3'b000, 0, 0, -1, '0);
    burst("R3", 1, 8'h35, 3'b001, 0, 0, -1, '0);
    burst("R4", 1, 8'h36, 3'b010, 0, 0, -1, '0);
    burst("R4", 1, 8'h4D, 3'b011, 0, 0, -1, '0);
  endtask

  task automatic t_interleave();
    burst("R5", 1, 8'h4D, 3'b011, 1, 0, -1, '0);
    burst("R5", 0, 8'h92, 3'b010, 1, 1, -1, '0);
  endtask

  task automatic t_full_page();
    burst("R6", 1, COLS - 3, 3'b111, 1, 0, 6, '0);
  endtask

  task automatic t_reserved_code();
    burst("R3", 1, 8'h12, 3'b101, 0, 0, -1, '0);
  endtask

  task automatic t_stop_mid();
    burst("R7", 1, 8'h20, 3'b011, 0, 0, 2, '0);
  endtask

  task automatic t_read_mask();
    burst("R9", 0, 8'h10, 3'b010, 0, 0, -1, 21'b0000000000000_0010_0010);
    burst("R10", 0, 8'h71, 3'b011, 0, 1, 4, 21'b0000000_0000_0100_1000_0);
  endtask

  task automatic t_write_mask();
    burst("R11", 1, 8'h44, 3'b011, 0, 1, -1, 21'b000000000000_0101_1010);
  endtask

  task automatic t_restart();
    @(negedge clk);
    go = 1; wr_en = 1; start_col = 8'h18; bl_code = 3'b011; ilv = 0; dqm = 0; stop = 0;
    for (int t = 1; t <= 14; t++) begin
      int e;
      @(negedge clk);
      go = (t == 3);
      if (t == 3) begin start_col = 8'hC2; bl_code = 3'b010; ilv = 1; end
      #1;
      if (t <= 3)      e = ecol(8'h18, t - 1, 3'b011, 0);
      else if (t <= 7) e = ecol(8'hC2, t - 4, 3'b010, 1);
      else             e = -1;
      chk(beat_vld == (e >= 0), "R8", "beat_vld", beat_vld, e >= 0);
      if (e >= 0) chk(int'(beat_col) == e, "R8", "beat_col", int'(beat_col), e);
    end
    go = 0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_seq_lengths();
        t_interleave();
        t_full_page();
        t_reserved_code();
        t_stop_mid();
        t_read_mask();
        t_write_mask();
        t_restart();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_checks++; n_fail++;
          $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
        end
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule